// File: doc/BRIEF.md
# Scalar Data Cache with Victim Buffer

This block is the first-level store for scalar data references. A direct-mapped main array of line-sized entries is backed by a small fully associative buffer that keeps lines recently pushed out of the main array. A CPU word request first checks the main array. If that misses, the victim buffer is probed before anything goes to the next memory level. Only when both structures miss is a whole line fetched from the next level.

On a victim hit the word is returned at once. A mode input selects what happens to the line. In swap mode the hit line moves into the main array and trades places with the line it conflicts with. In in-place mode the line stays in the buffer and the main array is left untouched. When a fetched line fills the main array, the line it displaces enters the victim buffer. The buffer makes room by dropping its least recently used entry, and writes that entry back first if it is dirty.

The CPU side uses a valid/ready handshake and accepts one request at a time; it stalls while a line fetch is outstanding. The next-level port issues one-beat line reads and line writes. Reads are answered by a single response pulse after the memory's fixed latency. Writes get no response.

Top module: `scalar_victim_cache`

## Requirements
- R1: A main-array hit returns the addressed word with resp_valid high exactly two clock edges after the accepting edge, and issues no next-level request.
- R2: A request that misses the main array but hits the victim buffer returns the correct word two edges after acceptance and issues no next-level request.
- R3: With swap_en high, a victim hit moves the hit line into the main array and the displaced main line into the victim buffer, so a following access to either line issues no next-level request.
- R4: With swap_en low, a victim hit is served from the buffer and the main array keeps its line, so a following access to the main line hits with no next-level request.
- R5: A miss in both structures issues exactly one line read (mem_req_write low) whose address is the request address with the low log2(line bytes) bits removed. The returned line fills the main array, and the displaced valid main line enters the victim buffer.
- R6: The victim buffer holds up to VICT_LINES lines. An insertion takes a free entry if one exists; otherwise it replaces the least recently used entry. Each victim hit and each insertion makes that entry the most recently used.
- R7: A replaced victim entry that is dirty is written back as a full line with its line address, in the cycle after the fill response. A clean one is dropped without any write.
- R8: A write sets the dirty bit of the line it lands in, whichever structure holds it. A dirty line keeps its dirty bit when it moves between structures. A write miss fetches the line and merges the new word into it.
- R9: req_ready goes low after an accepted request and stays low until the response; only one line read is outstanding at a time.
- R10: After reset req_ready is high, resp_valid and mem_req_valid are low, and every entry of both structures is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | 1: exchange lines on a victim hit; 0: serve a victim hit in place |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | WORD_W | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | WORD_W | Read data, valid with resp_valid |
| mem_req_valid | output | 1 | One-cycle next-level request |
| mem_req_write | output | 1 | 1 = line writeback, 0 = line read |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address |
| mem_req_wdata | output | LINE_BYTES*8 | Writeback line |
| mem_resp_valid | input | 1 | Read response pulse |
| mem_resp_rdata | input | LINE_BYTES*8 | Read response line |

## Verification
The hardest case to reach is a dirty line being dropped from a full victim buffer. The dirty line must first be written in the main array. It then has to be pushed into the buffer, and enough further conflicting lines must enter the buffer that it becomes least recently used. The stimulus writes one line, forces eight conflicting misses on the same index, and checks the writeback address and the written word. It then re-reads the line from memory. The in-place mode repeats this after a hit and a write have reordered the recency, which shows that touched entries survive and untouched ones leave first.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WAIT
  } vc_state_e;
endpackage

// File: rtl/vc_main_store.sv
module vc_main_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LINE_W-1:0] data_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  dirty_q;
  logic [IDX_W-1:0]  idx_q;

  // data array: synchronous read, single write port
  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_idx] <= wr_line;
    rd_line <= data_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    idx_q <= rd_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  assign rd_valid = valid_q[idx_q];
  assign rd_dirty = dirty_q[idx_q];
  assign rd_tag   = tag_mem[idx_q];
endmodule

// File: rtl/vc_victim_store.sv
module vc_victim_store #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 26,
  parameter int LINE_W  = 512,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic [LINE_W-1:0] hit_line,
  output logic              hit_dirty,
  output logic [SLOT_W-1:0] rep_slot,
  output logic              rep_valid,
  output logic              rep_dirty,
  output logic [TAG_W-1:0]  rep_tag,
  output logic [LINE_W-1:0] rep_line,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  logic [ENTRIES-1:0] vld_q, drt_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [SLOT_W-1:0]  rank_q [ENTRIES];  // 0 = most recent
  logic               free_found;

  always_comb begin
    hit       = 1'b0;
    hit_slot  = '0;
    hit_line  = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && tag_q[i] == lk_tag) begin
        hit       = 1'b1;
        hit_slot  = SLOT_W'(i);
        hit_line  = line_q[i];
        hit_dirty = drt_q[i];
      end
    end
  end

  always_comb begin
    free_found = 1'b0;
    rep_slot   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_found = 1'b1;
        rep_slot   = SLOT_W'(i);
      end
    end
    if (!free_found) begin
      for (int i = 0; i < ENTRIES; i++)
        if (rank_q[i] == SLOT_W'(ENTRIES - 1)) rep_slot = SLOT_W'(i);
    end
  end

  assign rep_valid = vld_q[rep_slot];
  assign rep_dirty = drt_q[rep_slot];
  assign rep_tag   = tag_q[rep_slot];
  assign rep_line  = line_q[rep_slot];

  // every write is a touch: the written slot becomes most recent
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      drt_q <= '0;
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= SLOT_W'(i);
    end else if (wr_en) begin
      vld_q[wr_slot] <= wr_valid;
      drt_q[wr_slot] <= wr_dirty;
      for (int i = 0; i < ENTRIES; i++) begin
        if (SLOT_W'(i) == wr_slot)           rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[wr_slot]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_slot]  <= wr_tag;
      line_q[wr_slot] <= wr_line;
    end
  end
endmodule

// File: rtl/scalar_victim_cache.sv
module scalar_victim_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAIN_LINES = 64,
  parameter int VICT_LINES = 8,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               swap_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               resp_valid,
  output logic [WORD_W-1:0]  resp_rdata,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic [LADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]  mem_req_wdata,
  input  logic               mem_resp_valid,
  input  logic [LINE_W-1:0]  mem_resp_rdata
);
  localparam int IDX_W  = $clog2(MAIN_LINES);
  localparam int TAG_W  = LADDR_W - IDX_W;
  localparam int WB_W   = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - WB_W;
  localparam int SLOT_W = $clog2(VICT_LINES);

  vc_state_e           state;
  logic                q_write;
  logic [ADDR_W-1:0]   q_addr;
  logic [WORD_W-1:0]   q_wdata;
  logic [IDX_W-1:0]    q_idx;
  logic [TAG_W-1:0]    q_tag;
  logic [LADDR_W-1:0]  q_laddr;
  logic [WSEL_W-1:0]   q_wsel;

  assign q_laddr = q_addr[ADDR_W-1:OFF_W];
  assign q_idx   = q_laddr[IDX_W-1:0];
  assign q_tag   = q_laddr[LADDR_W-1:IDX_W];
  assign q_wsel  = q_addr[OFF_W-1:WB_W];

  // main array signals
  logic [IDX_W-1:0]  rd_idx;
  logic [LINE_W-1:0] m_line;
  logic              m_valid, m_dirty, main_hit;
  logic [TAG_W-1:0]  m_tag;
  logic              mw_en, mw_dirty;
  logic [TAG_W-1:0]  mw_tag;
  logic [LINE_W-1:0] mw_line;

  // victim buffer signals
  logic               v_hit, v_dirty, rep_valid, rep_dirty;
  logic [SLOT_W-1:0]  v_slot, rep_slot;
  logic [LINE_W-1:0]  v_line, rep_line;
  logic [LADDR_W-1:0] rep_tag;
  logic               vw_en, vw_valid, vw_dirty;
  logic [SLOT_W-1:0]  vw_slot;
  logic [LADDR_W-1:0] vw_tag;
  logic [LINE_W-1:0]  vw_line;

  assign req_ready = (state == ST_IDLE);
  assign rd_idx    = (state == ST_IDLE) ? req_addr[OFF_W +: IDX_W] : q_idx;
  assign main_hit  = m_valid && (m_tag == q_tag);

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [WSEL_W-1:0] s,
                                                 input logic [WORD_W-1:0] w,
                                                 input logic en);
    logic [LINE_W-1:0] r;
    r = l;
    if (en) r[s*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  vc_main_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_line(m_line), .rd_valid(m_valid),
    .rd_dirty(m_dirty), .rd_tag(m_tag), .wr_en(mw_en), .wr_idx(q_idx),
    .wr_valid(1'b1), .wr_dirty(mw_dirty), .wr_tag(mw_tag), .wr_line(mw_line)
  );

  vc_victim_store #(.ENTRIES(VICT_LINES), .TAG_W(LADDR_W), .LINE_W(LINE_W)) u_vict (
    .clk(clk), .rst(rst), .lk_tag(q_laddr), .hit(v_hit), .hit_slot(v_slot),
    .hit_line(v_line), .hit_dirty(v_dirty), .rep_slot(rep_slot), .rep_valid(rep_valid),
    .rep_dirty(rep_dirty), .rep_tag(rep_tag), .rep_line(rep_line), .wr_en(vw_en),
    .wr_slot(vw_slot), .wr_valid(vw_valid), .wr_dirty(vw_dirty), .wr_tag(vw_tag),
    .wr_line(vw_line)
  );

  always_comb begin
    mw_en    = 1'b0;
    mw_dirty = 1'b0;
    mw_tag   = q_tag;
    mw_line  = '0;
    vw_en    = 1'b0;
    vw_slot  = v_slot;
    vw_valid = 1'b0;
    vw_dirty = 1'b0;
    vw_tag   = q_laddr;
    vw_line  = '0;
    if (state == ST_LOOK) begin
      if (main_hit) begin
        mw_en    = q_write;
        mw_dirty = 1'b1;
        mw_line  = put_word(m_line, q_wsel, q_wdata, 1'b1);
      end else if (v_hit) begin
        vw_en = 1'b1;
        if (swap_en) begin
          mw_en    = 1'b1;
          mw_dirty = v_dirty | q_write;
          mw_line  = put_word(v_line, q_wsel, q_wdata, q_write);
          vw_valid = m_valid;
          vw_dirty = m_dirty;
          vw_tag   = {m_tag, q_idx};
          vw_line  = m_line;
        end else begin
          vw_valid = 1'b1;
          vw_dirty = v_dirty | q_write;
          vw_line  = put_word(v_line, q_wsel, q_wdata, q_write);
        end
      end
    end else if (state == ST_WAIT && mem_resp_valid) begin
      mw_en    = 1'b1;
      mw_dirty = q_write;
      mw_line  = put_word(mem_resp_rdata, q_wsel, q_wdata, q_write);
      vw_en    = m_valid;
      vw_slot  = rep_slot;
      vw_valid = 1'b1;
      vw_dirty = m_dirty;
      vw_tag   = {m_tag, q_idx};
      vw_line  = m_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      q_write       <= 1'b0;
      q_addr        <= '0;
      q_wdata       <= '0;
      resp_valid    <= 1'b0;
      resp_rdata    <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (main_hit) begin
            resp_valid <= 1'b1;
            resp_rdata <= m_line[q_wsel*WORD_W +: WORD_W];
            state      <= ST_IDLE;
          end else if (v_hit) begin
            resp_valid <= 1'b1;
            resp_rdata <= v_line[q_wsel*WORD_W +: WORD_W];
            state      <= ST_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b0;
            mem_req_addr  <= q_laddr;
            state         <= ST_WAIT;
          end
        end
        ST_WAIT: if (mem_resp_valid) begin
          resp_valid <= 1'b1;
          resp_rdata <= mem_resp_rdata[q_wsel*WORD_W +: WORD_W];
          state      <= ST_IDLE;
          if (m_valid && rep_valid && rep_dirty) begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b1;
            mem_req_addr  <= rep_tag;
            mem_req_wdata <= rep_line;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vc_checker.sv
module vc_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic mem_req_valid,
  input logic mem_req_write,
  input logic mem_resp_valid
);
  p_accept_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  p_resp_after_busy_r1: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !$past(req_ready));

  p_read_while_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_write) |-> (!req_ready && !resp_valid));

  p_memreq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_wb_after_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> ($past(mem_resp_valid) && resp_valid));
endmodule

bind scalar_victim_cache vc_checker u_vc_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_write(mem_req_write), .mem_resp_valid(mem_resp_valid)
);

// File: tb/scalar_victim_cache_test.sv
`timescale 1ns/1ps
module scalar_victim_cache_test;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int LADDR_W = 26;
  localparam int LINE_W  = 512;
  localparam int MEM_LAT = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst = 1'b1, swap_en = 1'b1;
  logic               req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [WORD_W-1:0]  req_wdata = '0;
  logic               req_ready, resp_valid;
  logic [WORD_W-1:0]  resp_rdata;
  logic               mem_req_valid, mem_req_write;
  logic [LADDR_W-1:0] mem_req_addr;
  logic [LINE_W-1:0]  mem_req_wdata;
  logic               mem_resp_valid = 1'b0;
  logic [LINE_W-1:0]  mem_resp_rdata = '0;

  scalar_victim_cache uut (
    .clk(clk), .rst(rst), .swap_en(swap_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
    .mem_resp_rdata(mem_resp_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int mem_rd_cnt = 0, mem_wr_cnt = 0;
  logic [LADDR_W-1:0] last_wb_addr = '0, last_rd_addr = '0;
  logic [LINE_W-1:0]  last_wb_data = '0;
  logic [LINE_W-1:0]  backing [int];
  logic [WORD_W-1:0]  refw [int];

  typedef struct {
    bit          is_wr;
    logic [31:0] data;
    string       rq;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [31:0] ad(int tag, int idx, int word);
    return (32'(tag) << 12) | (32'(idx) << 6) | (32'(word) << 2);
  endfunction

  function automatic logic [LINE_W-1:0] init_line(logic [LADDR_W-1:0] la);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = {la, 6'(w*4)} ^ 32'h5A5A0000;
    return l;
  endfunction

  function automatic logic [31:0] exp_word(logic [31:0] a);
    if (refw.exists(int'(a))) return refw[int'(a)];
    return a ^ 32'h5A5A0000;
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // next-level memory model with fixed latency
  int pend_cnt = 0;
  logic [LADDR_W-1:0] pend_addr = '0;
  initial forever begin
    @(negedge clk);
    mem_resp_valid = 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        mem_resp_rdata = backing.exists(int'(pend_addr)) ? backing[int'(pend_addr)]
                                                         : init_line(pend_addr);
        mem_resp_valid = 1'b1;
      end
    end
    if (!rst && mem_req_valid) begin
      if (mem_req_write) begin
        backing[int'(mem_req_addr)] = mem_req_wdata;
        last_wb_addr = mem_req_addr;
        last_wb_data = mem_req_wdata;
        mem_wr_cnt++;
      end else begin
        last_rd_addr = mem_req_addr;
        pend_addr = mem_req_addr;
        pend_cnt = MEM_LAT;
        mem_rd_cnt++;
      end
    end
  end

  // monitor: pops expected responses
  initial forever begin
    @(negedge clk);
    if (!rst && resp_valid) begin
      if (sb_q.size() == 0) chk(1'b0, "R9", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        if (!e.is_wr) chk(resp_rdata == e.data, e.rq, "read data", resp_rdata, e.data);
      end
    end
  end

  // driver: one request, returns latency and memory traffic deltas
  task automatic access(bit wr, logic [31:0] addr, logic [31:0] wd, int exp_rd, int exp_wb,
                        int exp_lat, string rq);
    int rd0, wr0, lat;
    bit early_ready;
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd0 = mem_rd_cnt;
    wr0 = mem_wr_cnt;
    e.is_wr = wr;
    e.data  = exp_word(addr);
    e.rq    = rq;
    sb_q.push_back(e);
    if (wr) refw[int'(addr)] = wd;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    lat = 0;
    early_ready = 1'b0;
    do begin
      @(posedge clk); #1;
      req_valid = 1'b0;
      lat++;
      if (!resp_valid && req_ready) early_ready = 1'b1;
    end while (!resp_valid && lat < 100);
    @(negedge clk); #1;
    chk(!early_ready, "R9", "ready high before response", early_ready, 0);
    chk(mem_rd_cnt - rd0 == exp_rd, rq, "line reads", mem_rd_cnt - rd0, exp_rd);
    chk(mem_wr_cnt - wr0 == exp_wb, rq, "writebacks", mem_wr_cnt - wr0, exp_wb);
    if (exp_lat > 0) chk(lat == exp_lat, rq, "latency", lat, exp_lat);
    if (exp_rd > 0)
      chk(last_rd_addr == addr[31:6], "R5", "read line address", last_rd_addr, addr[31:6]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
    chk(resp_valid == 1'b0, "R10", "resp_valid", resp_valid, 0);
    chk(mem_req_valid == 1'b0, "R10", "mem_req_valid", mem_req_valid, 0);

    // swap mode, index 5
    access(0, ad(0,5,1), 0, 1, 0, 0, "R10");          // empty: miss
    access(0, ad(0,5,1), 0, 0, 0, 2, "R1");           // main hit
    access(1, ad(0,5,2), 32'hDEADBEEF, 0, 0, 2, "R8"); // write hit, dirty
    access(0, ad(1,5,0), 0, 1, 0, 0, "R5");           // A0 to victim
    access(0, ad(0,5,2), 0, 0, 0, 2, "R2");           // victim hit, swap
    access(0, ad(1,5,3), 0, 0, 0, 2, "R3");           // swapped-out line still held
    for (int t = 2; t <= 8; t++) access(0, ad(t,5,0), 0, 1, 0, 0, "R6");
    access(0, ad(9,5,0), 0, 1, 1, 0, "R7");           // dirty LRU leaves
    chk(last_wb_addr == ad(0,5,0) >> 6, "R7", "writeback address", last_wb_addr, ad(0,5,0) >> 6);
    chk(last_wb_data[2*32 +: 32] == 32'hDEADBEEF, "R8", "writeback word",
        last_wb_data[2*32 +: 32], 32'hDEADBEEF);
    access(0, ad(0,5,2), 0, 1, 0, 0, "R7");           // refetch, clean drop

    // in-place mode, index 9
    swap_en = 1'b0;
    for (int t = 0; t <= 8; t++) access(0, ad(t,9,0), 0, 1, 0, 0, "R6");
    access(0, ad(0,9,0), 0, 0, 0, 2, "R4");           // victim hit in place
    access(1, ad(1,9,0), 32'h12345678, 0, 0, 2, "R4"); // victim write in place
    access(0, ad(8,9,0), 0, 0, 0, 2, "R4");           // main line untouched
    access(0, ad(9,9,0), 0, 1, 0, 0, "R6");           // evicts B2
    access(0, ad(0,9,0), 0, 0, 0, 2, "R6");           // B0 kept by recency
    access(0, ad(2,9,0), 0, 1, 0, 0, "R6");           // B2 was dropped
    for (int t = 10; t <= 13; t++) access(0, ad(t,9,0), 0, 1, 0, 0, "R6");
    access(0, ad(14,9,0), 0, 1, 1, 0, "R7");          // dirty B1 leaves
    chk(last_wb_addr == ad(1,9,0) >> 6, "R7", "writeback address", last_wb_addr, ad(1,9,0) >> 6);
    chk(last_wb_data[31:0] == 32'h12345678, "R8", "writeback word", last_wb_data[31:0], 32'h12345678);
    access(0, ad(1,9,0), 0, 1, 0, 0, "R8");

    // write miss allocates and merges
    access(1, ad(0,20,3), 32'hCAFEF00D, 1, 0, 0, "R8");
    access(0, ad(0,20,3), 0, 0, 0, 2, "R8");
    access(0, ad(0,20,4), 0, 0, 0, 2, "R5");

    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "R9", "pending responses", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule